// File: doc/BRIEF.md
# Two-Stage Cascaded Clock Divider with Coarse Phase Steps

This block derives a slower output clock from a fast reference clock through two integer dividers in series. The fast stage divides the reference clock. The slow stage divides the fast stage's output. Each stage has its own coarse phase value, counted in periods of that stage's own input. A fast-stage step therefore moves the output by one reference period. A slow-stage step moves it by one full fast-stage period. Together the two values can place the output edges anywhere within one output period, which covers the whole range from -180 to +180 degrees.

All four configuration words are sampled at one moment only. That moment is the first clock edge after reset is released, or any later edge at which the `resync` strobe is high. At that edge both stage counters restart from preload values that produce the requested delay. Between these moments the configuration inputs may change freely. A phase value larger than its stage's ratio is reported on `cfg_err`, and the stage then uses its ratio minus one. All pins here are plain level or strobe controls, because no data stream passes through the block, so no handshake or back-pressure applies.

Top module: `casc_phase_div`

## Requirements
- R1: While `rst_n` is low, `clk_out` and `cfg_err` are both 0.
- R2: Let A be the fast ratio and B the slow ratio, where a value of 0 counts as 1. With B of 2 or more, `clk_out` has a period of A*B reference cycles and is high for A*ceil(B/2) of them. With B = 1, the period is A cycles and the output is high for ceil(A/2) of them. The high part starts the period.
- R3: A fast-stage phase value P1 with 0 < P1 < A delays every `clk_out` edge by P1 reference cycles.
- R4: A slow-stage phase value P2 with 0 < P2 < B delays every `clk_out` edge by P2*A reference cycles. This adds to the fast-stage delay, so the total delay is P1 + P2*A.
- R5: A phase value equal to its stage's ratio gives the same output as a phase value of 0.
- R6: `cfg_err` is 1 when the latched P1 > A or the latched P2 > B. Each stage whose phase exceeds its ratio applies a phase of its ratio minus one.
- R7: With B = 1 the slow stage is transparent and the output is the fast stage's waveform. With A = 1 the slow stage divides the reference directly. With A = B = 1, `clk_out` stays at 1.
- R8: The configuration is latched, and both counters restart, only at the first rising edge after reset release and at rising edges where `resync` is 1. At all other times, changes on the configuration inputs affect neither `clk_out` nor `cfg_err`.
- R9: `clk_out` is registered. Take the latching edge as cycle 0. The value of `clk_out` after edge k (k >= 1) is the R2 waveform at position k-1-D, where D is the total delay and position 0 is the start of a high part. Position k-1-D wraps modulo the output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resync | input | 1 | Latch configuration and restart the counters at this edge |
| div_fast | input | DW | Fast-stage divide ratio (0 treated as 1) |
| div_slow | input | DW | Slow-stage divide ratio (0 treated as 1) |
| ph_fast | input | DW | Fast-stage delay in reference periods |
| ph_slow | input | DW | Slow-stage delay in fast-stage output periods |
| clk_out | output | 1 | Divided, phase-shifted output clock |
| cfg_err | output | 1 | A latched phase value exceeds its stage's ratio |

## Verification
The hardest case to reach is a non-zero fast-stage offset combined with a slow-stage offset. In that case the slow stage must account for the partial fast-stage period that leads the output. An error there shifts the output by exactly one fast-stage period, and only when both offsets are non-zero. The stimulus therefore latches several settings with both offsets set, one with an offset equal to its ratio, and one with a clamped offset. It compares whole output periods cycle by cycle against a delayed ideal waveform. It then changes the inputs without a strobe, to show that the running waveform continues unchanged.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  // number of cascaded divider stages in the output path
  localparam int CPD_STAGES = 2;
  // index of each stage in the chain
  localparam int CPD_FAST = 0;
  localparam int CPD_SLOW = 1;
endpackage

// File: rtl/cpd_stage.sv
module cpd_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  logic          adv,
  input  logic          lead_in,
  input  logic [DW-1:0] ratio_in,
  input  logic [DW-1:0] phase_in,
  output logic          wrap,
  output logic          lead_out,
  output logic          level,
  output logic          err,
  output logic          one,
  output logic [DW-1:0] ratio_act,
  output logic [DW-1:0] cnt_act
);
  localparam int CW = DW + 1;

  logic [DW-1:0] n_eff, p_eff, load_v;
  logic [CW-1:0] sub, half;
  logic          bad;
  logic [DW-1:0] n_q, cnt_q;
  logic          err_q;

  // effective ratio, clamped phase and counter preload
  always_comb begin
    n_eff = (ratio_in == '0) ? DW'(1) : ratio_in;
    bad   = phase_in > n_eff;
    if (bad)
      p_eff = n_eff - DW'(1);
    else if (phase_in == n_eff)
      p_eff = '0;
    else
      p_eff = phase_in;
    // lead_in: upstream stage starts with a partial period, absorb it here
    sub = {1'b0, p_eff} + CW'(lead_in);
    if (sub == '0 || sub == {1'b0, n_eff})
      load_v = '0;
    else
      load_v = n_eff - sub[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= DW'(1);
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (apply) begin
      n_q   <= n_eff;
      cnt_q <= load_v;
      err_q <= bad;
    end else if (adv) begin
      if (cnt_q == n_q - DW'(1))
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + DW'(1);
    end
  end

  assign half      = ({1'b0, n_q} + CW'(1)) >> 1;
  assign level     = {1'b0, cnt_q} < half;
  assign wrap      = adv && (cnt_q == n_q - DW'(1));
  assign lead_out  = p_eff != '0;
  assign err       = err_q;
  assign one       = n_q == DW'(1);
  assign ratio_act = n_q;
  assign cnt_act   = cnt_q;
endmodule

// File: rtl/casc_phase_div.sv
module casc_phase_div
  import cpd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resync,
  input  logic [DW-1:0] div_fast,
  input  logic [DW-1:0] div_slow,
  input  logic [DW-1:0] ph_fast,
  input  logic [DW-1:0] ph_slow,
  output logic          clk_out,
  output logic          cfg_err
);
  localparam int NS = CPD_STAGES;

  logic                   armed_q, apply, out_lvl;
  logic [NS-1:0]          adv_v, lead_in_v, wrap_v, lead_v, level_v, err_v, one_v;
  logic [NS-1:0][DW-1:0]  ratio_in_v, phase_in_v, ratio_act, cnt_act;

  assign ratio_in_v[CPD_FAST] = div_fast;
  assign ratio_in_v[CPD_SLOW] = div_slow;
  assign phase_in_v[CPD_FAST] = ph_fast;
  assign phase_in_v[CPD_SLOW] = ph_slow;

  // first edge after reset latches the configuration like a strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end
  assign apply = resync | ~armed_q;

  for (genvar i = 0; i < NS; i++) begin : g_stg
    if (i == 0) begin : g_head
      assign adv_v[i]     = 1'b1;
      assign lead_in_v[i] = 1'b0;
    end else begin : g_tail
      assign adv_v[i]     = wrap_v[i-1];
      assign lead_in_v[i] = lead_v[i-1];
    end
    cpd_stage #(.DW(DW)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (apply),
      .adv       (adv_v[i]),
      .lead_in   (lead_in_v[i]),
      .ratio_in  (ratio_in_v[i]),
      .phase_in  (phase_in_v[i]),
      .wrap      (wrap_v[i]),
      .lead_out  (lead_v[i]),
      .level     (level_v[i]),
      .err       (err_v[i]),
      .one       (one_v[i]),
      .ratio_act (ratio_act[i]),
      .cnt_act   (cnt_act[i])
    );
  end

  // slow stage at ratio 1 is transparent
  assign out_lvl = one_v[CPD_SLOW] ? level_v[CPD_FAST] : level_v[CPD_SLOW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clk_out <= 1'b0;
    else if (armed_q) clk_out <= out_lvl;
  end

  assign cfg_err = |err_v;
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          resync,
  input logic          clk_out,
  input logic          cfg_err,
  input logic [1:0]    wrap_v,
  input logic [1:0]    lead_v,
  input logic [DW-1:0] r_fast,
  input logic [DW-1:0] r_slow,
  input logic [DW-1:0] c_fast,
  input logic [DW-1:0] c_slow
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!clk_out && !cfg_err);
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync && $past(rst_n)) |=> $stable(cfg_err));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fast < r_fast) && (c_slow < r_slow));

  // R2
  rise_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_v[1] && !resync && $past(rst_n)) |=> ##1 clk_out);

  // R3
  zero_offset_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && $past(rst_n) && !lead_v[0] && !lead_v[1]) |=> ##1 clk_out);

  // R7
  both_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_fast == DW'(1) && r_slow == DW'(1) && $past(rst_n)) |=> clk_out);
endmodule

bind casc_phase_div cpd_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .resync  (resync),
  .clk_out (clk_out),
  .cfg_err (cfg_err),
  .wrap_v  (wrap_v),
  .lead_v  (lead_v),
  .r_fast  (ratio_act[0]),
  .r_slow  (ratio_act[1]),
  .c_fast  (cnt_act[0]),
  .c_slow  (cnt_act[1])
);

// File: tb/casc_phase_div_test.sv
`timescale 1ns/1ps
module casc_phase_div_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          resync = 1'b0;
  logic [DW-1:0] div_fast = 8'd2, div_slow = 8'd2, ph_fast = 8'd1, ph_slow = 8'd0;
  logic          clk_out, cfg_err;

  int total = 0, bad = 0;
  bit done = 0;

  // latched configuration as the bench understands it
  int c_n1, c_n2, c_p1, c_p2, kpos;

  bit    q_out[$];
  bit    q_err[$];
  string q_tag[$];

  casc_phase_div #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .resync(resync),
    .div_fast(div_fast), .div_slow(div_slow),
    .ph_fast(ph_fast), .ph_slow(ph_slow),
    .clk_out(clk_out), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  function automatic int eff_n(int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int eff_p(int p, int n);
    if (p > n) return n - 1;
    if (p == n) return 0;
    return p;
  endfunction

  // ideal output after edge k, from R2/R3/R4/R9
  function automatic bit ideal(int k);
    int a = eff_n(c_n1);
    int b = eff_n(c_n2);
    int d = eff_p(c_p1, a) + eff_p(c_p2, b) * a;
    int per = a * b;
    int u = ((k - 1 - d) % per + per) % per;
    if (b == 1) return (u % a) < (a + 1) / 2;
    return (u / a) < (b + 1) / 2;
  endfunction

  task automatic check(string tag, bit act, bit exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic push(int len, string tag);
    bit e = (c_p1 > eff_n(c_n1)) || (c_p2 > eff_n(c_n2));
    for (int i = 0; i < len; i++) begin
      kpos++;
      q_out.push_back(ideal(kpos));
      q_err.push_back(e);
      q_tag.push_back(tag);
    end
  endtask

  task automatic drain();
    while (q_out.size() != 0) @(negedge clk);
  endtask

  // latch a configuration with a one-cycle strobe, then score len cycles
  task automatic run_cfg(int n1, int n2, int p1, int p2, int len, string tag);
    div_fast = DW'(n1); div_slow = DW'(n2);
    ph_fast = DW'(p1);  ph_slow = DW'(p2);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    c_n1 = n1; c_n2 = n2; c_p1 = p1; c_p2 = p2; kpos = 0;
    push(len, tag);
    drain();
  endtask

  // monitor: compare one scoreboard item per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_out.size() != 0) begin
        bit eo, ee;
        string t;
        eo = q_out.pop_front();
        ee = q_err.pop_front();
        t  = q_tag.pop_front();
        check(t, clk_out, eo, "clk_out");
        check(t, cfg_err, ee, "cfg_err");
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: idle during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", clk_out, 1'b0, "clk_out in reset");
      check("R1", cfg_err, 1'b0, "cfg_err in reset");
    end
    // R8: first edge after release latches without a strobe (2,2,1,0)
    rst_n = 1'b1;
    @(negedge clk);
    c_n1 = 2; c_n2 = 2; c_p1 = 1; c_p2 = 0; kpos = 0;
    push(12, "R8");
    drain();

    run_cfg(3, 1, 0, 0, 12, "R7");   // slow stage transparent
    run_cfg(2, 3, 0, 0, 18, "R2");   // period 6, high 4
    run_cfg(3, 4, 2, 0, 30, "R3");   // fast-stage delay
    run_cfg(3, 4, 0, 3, 30, "R4");   // slow-stage delay
    run_cfg(3, 4, 1, 2, 30, "R4");   // both delays combined
    run_cfg(4, 2, 4, 2, 20, "R5");   // offsets equal ratios
    run_cfg(5, 3, 7, 0, 30, "R6");   // clamp to 4, flag error
    run_cfg(5, 3, 0, 9, 30, "R6");   // slow clamp to 2
    run_cfg(1, 5, 0, 2, 15, "R7");   // fast stage transparent
    run_cfg(1, 1, 0, 0, 8,  "R7");   // constant high
    run_cfg(3, 4, 1, 2, 24, "R9");

    // R8: inputs change with no strobe, waveform and flag continue
    div_fast = 8'd9; div_slow = 8'd0; ph_fast = 8'd20; ph_slow = 8'd20;
    push(36, "R8");
    drain();

    // R1: asynchronous return to reset
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", clk_out, 1'b0, "clk_out after reset");
    check("R1", cfg_err, 1'b0, "cfg_err after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule